// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous timer input before the timer logic uses it. The raw pin first goes through a two-flop synchroniser. It is then sampled at a rate chosen by a 4-bit filter code. The sample rate is either every kernel clock cycle or a division of a slower dead-time clock. That slower clock is modelled as a single-cycle enable, `dts_ce_i`, inside the kernel clock domain. The filtered level moves to a new value only after a run of consecutive samples that all show that value. Any shorter pulse is discarded.

The same 4-bit code selects three things: the sample source, the division factor and the run length N. The mapping is fixed and irregular. The block also gives one-cycle rising and falling strobes that mark each change of the filtered level. A change of code restarts both the run counter and the sampling divider. Because of this, a new setting never inherits a count made under the old one.

Top module: `pin_glitch_filter`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `level_o`, `rise_o` and `fall_o` are all 0.
- R2: Codes 1, 2 and 3 sample on every kernel cycle with N = 2, 4 and 8. If the pin changes before a clock edge and then holds, `level_o` takes the new value after the (N+2)-th kernel edge, counting that edge as the first one.
- R3: Code 0 applies no filtering (N = 1) and samples on each cycle where `dts_ce_i` is 1. With `dts_ce_i` held at 1, a change on the pin reaches `level_o` after the third edge.
- R4: The dead-time codes sample on every D-th enable pulse, and they take the following D and N values:
  - codes 4 and 5: D = 2, with N = 6 and N = 8;
  - codes 6 and 7: D = 4, with N = 6 and N = 8;
  - codes 8 and 9: D = 8, with N = 6 and N = 8;
  - codes 10, 11 and 12: D = 16, with N = 5, 6 and 8;
  - codes 13, 14 and 15: D = 32, with N = 5, 6 and 8.
- R5: A pin pulse that yields fewer than N consecutive samples at the opposite level leaves `level_o` unchanged.
- R6: A sample that equals the current `level_o` clears the run count. Runs separated by such a sample do not add up.
- R7: In a cycle where `code_i` differs from its value in the previous cycle, two things happen: the run count and the divider are cleared, and no sample is taken.
- R8: `rise_o` (or `fall_o`) is high for exactly the one kernel cycle in which `level_o` first shows 1 (or 0). Neither strobe is high at any other time.
- R9: For dead-time codes, the divider advances only on cycles where `dts_ce_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dts_ce_i | input | 1 | Dead-time clock enable, one kernel cycle per dead-time tick |
| pin_i | input | 1 | Raw asynchronous input |
| code_i | input | 4 | Filter code selecting sample rate and run length |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle strobe on a 0-to-1 change of level_o |
| fall_o | output | 1 | One-cycle strobe on a 1-to-0 change of level_o |

## Verification
Two functions can land in the same cycle: a code change, and the sample tick that would complete a run of N. A directed case sets up this collision on purpose. With code 3 selected, it holds the pin high for five counted samples and then switches to code 2 on the very edge where the sixth sample would have been taken. The correct result is that the change wins: the count restarts, and `level_o` rises exactly four samples later, not at once. The long sweeps step through codes at arbitrary divider phases and compare every cycle against an arithmetic model, so the same collision is also met there without being set up.

// File: rtl/glf_pkg.sv
package glf_pkg;

  localparam int CODE_W   = 4;
  localparam int DLOG_MAX = 5;
  localparam int NEED_W   = 4;

  typedef struct packed {
    logic                  use_kernel;
    logic [2:0]            div_log2;
    logic [NEED_W-1:0]     need;
  } glf_cfg_t;

  function automatic glf_cfg_t glf_decode(input logic [CODE_W-1:0] code);
    glf_cfg_t c;
    c.use_kernel = 1'b0;
    c.div_log2   = 3'd0;
    c.need       = 4'd1;
    case (code)
      4'd0:  c.need = 4'd1;
      4'd1:  begin c.use_kernel = 1'b1; c.need = 4'd2; end
      4'd2:  begin c.use_kernel = 1'b1; c.need = 4'd4; end
      4'd3:  begin c.use_kernel = 1'b1; c.need = 4'd8; end
      4'd4:  begin c.div_log2 = 3'd1; c.need = 4'd6; end
      4'd5:  begin c.div_log2 = 3'd1; c.need = 4'd8; end
      4'd6:  begin c.div_log2 = 3'd2; c.need = 4'd6; end
      4'd7:  begin c.div_log2 = 3'd2; c.need = 4'd8; end
      4'd8:  begin c.div_log2 = 3'd3; c.need = 4'd6; end
      4'd9:  begin c.div_log2 = 3'd3; c.need = 4'd8; end
      4'd10: begin c.div_log2 = 3'd4; c.need = 4'd5; end
      4'd11: begin c.div_log2 = 3'd4; c.need = 4'd6; end
      4'd12: begin c.div_log2 = 3'd4; c.need = 4'd8; end
      4'd13: begin c.div_log2 = 3'd5; c.need = 4'd5; end
      4'd14: begin c.div_log2 = 3'd5; c.need = 4'd6; end
      default: begin c.div_log2 = 3'd5; c.need = 4'd8; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/glf_tick_gen.sv
module glf_tick_gen #(
  parameter int DLOG_MAX = 5,
  localparam int DIV_W   = DLOG_MAX
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       clr_i,
  input  logic       dts_ce_i,
  input  logic       use_kernel_i,
  input  logic [2:0] div_log2_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic             at_last;

  assign div_last = (DIV_W'(1) << div_log2_i) - DIV_W'(1);
  assign at_last  = (div_cnt == div_last);

  always_comb begin
    if (clr_i)             tick_o = 1'b0;
    else if (use_kernel_i) tick_o = 1'b1;
    else                   tick_o = dts_ce_i && at_last;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      div_cnt <= '0;
    end else if (!use_kernel_i && dts_ce_i) begin
      div_cnt <= at_last ? '0 : div_cnt + DIV_W'(1);
    end
  end

  AST_DIV_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!use_kernel_i && !clr_i && dts_ce_i && at_last) |=> (div_cnt == '0)); // R4

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!clr_i && !dts_ce_i) |=> $stable(div_cnt)); // R9

endmodule

// File: rtl/glf_level_filter.sv
module glf_level_filter #(
  parameter int NEED_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              sample_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [NEED_W-1:0] run_cnt;
  logic [NEED_W-1:0] run_inc;

  assign run_inc = run_cnt + NEED_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_o <= 1'b0;
      run_cnt <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (clr_i) begin
        run_cnt <= '0;
      end else if (tick_i) begin
        if (sample_i == level_o) begin
          run_cnt <= '0;
        end else if (run_inc >= need_i) begin
          level_o <= sample_i;
          run_cnt <= '0;
          rise_o  <= sample_i;
          fall_o  <= !sample_i;
        end else begin
          run_cnt <= run_inc;
        end
      end
    end
  end

  AST_RUN_BELOW_NEED: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_i |-> (run_cnt < need_i)); // R6

  AST_CLR_ZEROES_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (run_cnt == '0)); // R7

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
  import glf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              dts_ce_i,
  input  logic              pin_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [CODE_W-1:0] code_prev;
  logic              code_chg;
  glf_cfg_t          cfg;
  logic              pin_sync;
  logic              tick;

  assign cfg      = glf_decode(code_i);
  assign code_chg = (code_i != code_prev);

  always_ff @(posedge clk_i) begin
    if (rst_i) code_prev <= '0;
    else       code_prev <= code_i;
  end

  glf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  glf_tick_gen #(.DLOG_MAX(DLOG_MAX)) u_tick (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .clr_i        (code_chg),
    .dts_ce_i     (dts_ce_i),
    .use_kernel_i (cfg.use_kernel),
    .div_log2_i   (cfg.div_log2),
    .tick_o       (tick)
  );

  glf_level_filter #(.NEED_W(NEED_W)) u_filt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clr_i    (code_chg),
    .tick_i   (tick),
    .sample_i (pin_sync),
    .need_i   (cfg.need),
    .level_o  (level_o),
    .rise_o   (rise_o),
    .fall_o   (fall_o)
  );

  AST_RISE_MARKS_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |-> (level_o && !$past(level_o))); // R8

  AST_FALL_MARKS_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    fall_o |-> (!level_o && $past(level_o))); // R8

  AST_QUIET_MEANS_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rise_o && !fall_o) |-> $stable(level_o)); // R8

endmodule

// File: tb/pin_glitch_filter_tb.sv
module pin_glitch_filter_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       ce;
  logic       pin;
  logic [3:0] code;
  logic       level, rise, fall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit cmp_en = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pin_glitch_filter dut_i (
    .clk_i(clk), .rst_i(rst), .dts_ce_i(ce), .pin_i(pin),
    .code_i(code), .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  function automatic int need_of(input int c);
    int t[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
    return t[c];
  endfunction

  function automatic int div_of(input int c);
    if (c < 4) return 1;
    if (c < 10) return 1 << ((c - 2) / 2);
    if (c < 13) return 16;
    return 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference model, derived arithmetically from the requirements
  logic m_s1, m_s2, m_lvl, m_rise, m_fall;
  logic [3:0] m_cp;
  int m_div, m_run;
  always @(posedge clk) begin : model
    bit kern;
    bit smp;
    int d, n;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_rise <= 0; m_fall <= 0;
      m_cp <= 0; m_div <= 0; m_run <= 0;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_cp <= code;
      m_rise <= 0; m_fall <= 0;
      kern = (code >= 1 && code <= 3);
      d = div_of(int'(code));
      n = need_of(int'(code));
      if (code != m_cp) begin
        m_div <= 0; m_run <= 0;
      end else begin
        smp = kern ? 1'b1 : (ce && ((m_div + 1) % d == 0));
        if (!kern && ce) m_div <= (m_div + 1) % d;
        if (smp) begin
          if (m_s2 == m_lvl) m_run <= 0;
          else if (m_run + 1 == n) begin
            m_lvl <= m_s2; m_run <= 0; m_rise <= m_s2; m_fall <= !m_s2;
          end else m_run <= m_run + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
    if (cmp_en) begin
      chk(level == m_lvl, "R4 level vs model", level, m_lvl);
      chk(rise == m_rise && fall == m_fall, "R8 strobes vs model",
          {rise, fall}, {m_rise, m_fall});
    end
  end

  task automatic settle(input logic [3:0] c);
    code = c; pin = 0; ce = 1;
    repeat (40) @(negedge clk);
  endtask

  task automatic latency(input logic [3:0] c, input int n, input string tag);
    settle(c);
    for (int v = 1; v >= 0; v--) begin
      pin = v[0];
      for (int k = 1; k <= n + 3; k++) begin
        @(negedge clk);
        if (k == n + 1) chk(level == !v[0], tag, level, !v[0]);
        if (k == n + 2) begin
          chk(level == v[0], tag, level, v[0]);
          chk((v[0] ? rise : fall) == 1'b1, "R8 strobe on change", v[0] ? rise : fall, 1);
        end
        if (k == n + 3) chk(rise == 0 && fall == 0, "R8 strobe one cycle", {rise, fall}, 0);
      end
    end
  endtask

  initial begin
    bit saw;
    logic [15:0] lf;
    rst = 1; ce = 0; pin = 0; code = 0;
    repeat (3) @(negedge clk);
    chk(level == 0 && rise == 0 && fall == 0, "R1 in reset", {level, rise, fall}, 0);
    rst = 0;
    @(negedge clk);
    chk(level == 0 && rise == 0 && fall == 0, "R1 after reset", {level, rise, fall}, 0);
    cmp_en = 1;

    latency(4'd0, 1, "R3 code0 latency");
    latency(4'd1, 2, "R2 code1 latency");
    latency(4'd2, 4, "R2 code2 latency");
    latency(4'd3, 8, "R2 code3 latency");

    // R5: seven samples high with N=8 must be dropped
    settle(4'd3);
    pin = 1; repeat (7) @(negedge clk); pin = 0;
    saw = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (level || rise) saw = 1; end
    chk(!saw, "R5 short pulse ignored", saw, 0);

    // R6: 5 high, 1 low, 5 high never reaches 8
    settle(4'd3);
    pin = 1; repeat (5) @(negedge clk);
    pin = 0; @(negedge clk);
    pin = 1; repeat (5) @(negedge clk);
    pin = 0;
    saw = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (level || rise) saw = 1; end
    chk(!saw, "R6 run restarts", saw, 0);

    // R7: code change collides with the sixth sample
    settle(4'd3);
    pin = 1;
    repeat (7) @(negedge clk);
    code = 4'd2;
    for (int k = 8; k <= 12; k++) begin
      @(negedge clk);
      if (k == 11) chk(level == 0, "R7 count cleared on code change", level, 0);
      if (k == 12) chk(level == 1, "R7 accept after new N", level, 1);
    end
    settle(4'd1);

    // R9: no enable pulses, divided code never samples
    code = 4'd4; ce = 0; pin = 1;
    repeat (60) @(negedge clk);
    chk(level == 0, "R9 divider idle without enable", level, 0);
    pin = 0; settle(4'd1);

    // sweep every code with random enable and pin patterns
    lf = 16'hACE1;
    for (int c = 0; c < 16; c++) begin
      int span, hold;
      code = 4'(c);
      span = 3 * need_of(c) * div_of(c) + 2;
      hold = 1;
      for (int t = 0; t < 5600; t++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ce = (lf[1:0] != 2'b00);
        hold--;
        if (hold <= 0) begin
          pin = ~pin;
          hold = 1 + int'(lf) % span;
        end
        @(negedge clk);
      end
    end
    finish_run();
  end

endmodule